// File: doc/BRIEF.md
# Early Branch Condition Resolver

This block sits in the decode stage of a simple in-order pipeline, directly after the register file read. It decides conditional branches there instead of in the execute-stage ALU, so the fetch unit can be redirected one cycle sooner. Two-register conditions are limited to equal and not-equal, and are decided with an XOR of the operands followed by an OR-reduction, with no adder in the path. Magnitude conditions compare only the first operand against zero, using its sign bit and a zero detect.

A general "a less than b" branch is not offered. Software builds it from the separate set-less-than result that this block passes on to the ALU stage, followed by a branch on that result being zero or nonzero. The block also forms the branch target from the PC and a sign-extended word offset, and it issues a one-cycle redirect strobe for every qualified branch that is taken.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_n` is low, at every rising clock edge `br_taken`, `redirect`, `br_target` and `slt_out` are all cleared to zero.
- R2: Opcode 1 (equal) is taken when `opa` equals `opb` in all 32 bits. Opcode 2 (not-equal) is taken when they differ in any bit. The outcome is visible on `br_taken` one clock after the inputs are sampled.
- R3: Opcodes 3 (less than zero), 4 (less or equal zero), 5 (greater than zero) and 6 (greater or equal zero) treat `opa` as a signed value and compare it with zero, with `opb` having no effect on the outcome.
- R4: Opcodes 0 and 7 are not branches. A valid cycle that carries either one yields `br_taken` = 0 and no redirect.
- R5: On every clock where `in_valid` is high, `br_target` is loaded with `pc + 4 + (offset << 2)`, taken modulo 2^32.
- R6: `redirect` is high for exactly the one cycle that follows a clock where `in_valid` was high and the branch was taken. It is low after any clock where `in_valid` was low.
- R7: After a clock where `in_valid` is low, `br_taken` and `br_target` keep the values they held before.
- R8: `slt_out` is 1 or 0 one clock after sampling. It is 1 when `opa` is less than `opb`, compared as two's-complement numbers when `slt_unsigned` is 0 and as unsigned numbers when it is 1. Bits 31 to 1 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the opcode and operands this cycle |
| br_op | input | 3 | Branch opcode: 0 none, 1 equal, 2 not-equal, 3 <0, 4 <=0, 5 >0, 6 >=0, 7 none |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| pc | input | 32 | Address of the branch instruction |
| offset | input | 32 | Sign-extended word offset of the branch |
| slt_unsigned | input | 1 | Selects an unsigned set-less-than when 1 |
| br_taken | output | 1 | Outcome of the last qualified opcode |
| br_target | output | 32 | Target address of the last qualified opcode |
| redirect | output | 1 | One-cycle strobe telling fetch to go to `br_target` |
| slt_out | output | 32 | Set-less-than result handed to the ALU stage |

## Verification
Every output of this block comes from one register stage. `br_taken`, `br_target`, `redirect` and `slt_out` therefore reflect the inputs sampled at the rising edge just before them. The bench drives each vector on a falling edge, lets one rising edge capture it, and compares at the next falling edge. At that same falling edge it also drives the following vector. The sweep pairs seven corner operands (zero, one, minus one, the extremes and small signed values) across all eight opcodes, with valid both high and low. This checks the hold behaviour and the one-cycle strobe against a model kept in the bench.

// File: rtl/brr_pkg.sv
// Package brr_pkg
// Purpose : shared opcode encoding for the early branch resolver.
// Assumes : opcodes arrive already decoded to this 3-bit code.
package brr_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        BR_NONE = 3'd0,
        BR_EQ   = 3'd1,
        BR_NE   = 3'd2,
        BR_LTZ  = 3'd3,
        BR_LEZ  = 3'd4,
        BR_GTZ  = 3'd5,
        BR_GEZ  = 3'd6,
        BR_RSVD = 3'd7
    } br_op_e;

endpackage

// File: rtl/brr_eq_cmp.sv
// Module brr_eq_cmp
// Purpose : adder-free equality detect. Each operand bit pair is XORed,
//           each lane is OR-reduced, and the lane results are then OR-reduced.
// Assumes : purely combinational; LANE_W is at least 1.
module brr_eq_cmp #(
    parameter int XLEN   = 32,
    parameter int LANE_W = 8
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            equal
);
    localparam int LANES = (XLEN + LANE_W - 1) / LANE_W;
    localparam int PAD_W = LANES * LANE_W;

    logic [PAD_W-1:0] diff_pad;
    logic [LANES-1:0] lane_any;

    // Bitwise difference, zero padded up to a whole number of lanes.
    always_comb begin
        diff_pad             = '0;
        diff_pad[XLEN-1:0]   = a ^ b;
    end

    // One OR-reduce per lane keeps each gate shallow.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_any[g] = |diff_pad[g*LANE_W +: LANE_W];
    end

    // The operands are equal when no lane holds a differing bit.
    assign equal = ~|lane_any;

endmodule

// File: rtl/brr_zero_cond.sv
// Module brr_zero_cond
// Purpose : evaluates the four compare-with-zero conditions using only the
//           sign bit and a zero detect of the first operand.
// Assumes : operand is two's complement; non-zero-compare opcodes give 0.
module brr_zero_cond
    import brr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  br_op_e          op,
    output logic            hit
);
    logic neg;
    logic zero;

    assign neg  = a[XLEN-1];
    assign zero = ~|a;

    // Pick the condition for the opcode from sign and zero flags.
    always_comb begin
        unique case (op)
            BR_LTZ:  hit = neg;
            BR_LEZ:  hit = neg | zero;
            BR_GTZ:  hit = ~neg & ~zero;
            BR_GEZ:  hit = ~neg;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/brr_target.sv
// Module brr_target
// Purpose : forms the branch target as the next sequential address plus
//           the word offset scaled to bytes.
// Assumes : offset is already sign-extended to XLEN; wraparound is modulo 2^XLEN.
module brr_target #(
    parameter int XLEN    = 32,
    parameter int PC_STEP = 4,
    parameter int SHIFT   = 2
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] target
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] byte_off;

    // Sequential address and scaled offset, then a single add.
    always_comb begin
        seq_pc   = pc + STEP;
        byte_off = offset << SHIFT;
        target   = seq_pc + byte_off;
    end

endmodule

// File: rtl/brr_slt.sv
// Module brr_slt
// Purpose : set-less-than for the ALU stage, signed or unsigned. The signed
//           result comes from the difference sign corrected by the overflow.
// Assumes : combinational; the result is registered by the parent.
module brr_slt #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            uns,
    output logic            less
);
    logic [XLEN:0]   diff;
    logic [XLEN-1:0] res;
    logic            borrow;
    logic            ovf;
    logic            lt_s;

    // Widened subtract: the top bit is the unsigned borrow.
    always_comb begin
        diff   = {1'b0, a} - {1'b0, b};
        res    = diff[XLEN-1:0];
        borrow = diff[XLEN];
        ovf    = (a[XLEN-1] ^ b[XLEN-1]) & (res[XLEN-1] ^ a[XLEN-1]);
        lt_s   = res[XLEN-1] ^ ovf;
        less   = uns ? borrow : lt_s;
    end

endmodule

// File: rtl/branch_resolver.sv
// Module branch_resolver
// Purpose : decode-stage branch resolver. Decides equal/not-equal and
//           compare-with-zero conditions, forms the target, strobes redirect,
//           and registers a set-less-than result for the ALU stage.
// Assumes : operands come straight from the register file read; in_valid
//           qualifies br_op; synchronous active-low reset.
module branch_resolver
    import brr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int LANE_W  = 8,
    parameter int PC_STEP = 4,
    parameter int SHIFT   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      br_op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    input  logic            slt_unsigned,
    output logic            br_taken,
    output logic [XLEN-1:0] br_target,
    output logic            redirect,
    output logic [XLEN-1:0] slt_out
);
    br_op_e          op;
    logic            ops_equal;
    logic            zero_hit;
    logic            cond;
    logic [XLEN-1:0] target_d;
    logic            less;

    assign op = br_op_e'(br_op);

    brr_eq_cmp #(.XLEN(XLEN), .LANE_W(LANE_W)) u_eq (
        .a     (opa),
        .b     (opb),
        .equal (ops_equal)
    );

    brr_zero_cond #(.XLEN(XLEN)) u_zc (
        .a   (opa),
        .op  (op),
        .hit (zero_hit)
    );

    brr_target #(.XLEN(XLEN), .PC_STEP(PC_STEP), .SHIFT(SHIFT)) u_tgt (
        .pc     (pc),
        .offset (offset),
        .target (target_d)
    );

    brr_slt #(.XLEN(XLEN)) u_slt (
        .a    (opa),
        .b    (opb),
        .uns  (slt_unsigned),
        .less (less)
    );

    // Merge the two-register and compare-with-zero decisions by opcode.
    always_comb begin
        unique case (op)
            BR_EQ:   cond = ops_equal;
            BR_NE:   cond = ~ops_equal;
            BR_LTZ, BR_LEZ, BR_GTZ, BR_GEZ: cond = zero_hit;
            default: cond = 1'b0;
        endcase
    end

    // Hold the outcome and target of the last qualified opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_taken  <= 1'b0;
            br_target <= '0;
        end else if (in_valid) begin
            br_taken  <= cond;
            br_target <= target_d;
        end
    end

    // Strobe redirect for one cycle per valid taken branch.
    always_ff @(posedge clk) begin
        if (!rst_n) redirect <= 1'b0;
        else        redirect <= in_valid & cond;
    end

    // Register the set-less-than result into the ALU stage.
    always_ff @(posedge clk) begin
        if (!rst_n) slt_out <= '0;
        else        slt_out <= {{(XLEN-1){1'b0}}, less};
    end

endmodule

// File: rtl/brr_checker.sv
// Module brr_checker
// Purpose : temporal checks on the resolver's ports, bound to every instance.
// Assumes : same parameters as the bound resolver.
module brr_checker #(
    parameter int XLEN    = 32,
    parameter int PC_STEP = 4,
    parameter int SHIFT   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      br_op,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] offset,
    input logic            br_taken,
    input logic [XLEN-1:0] br_target,
    input logic            redirect,
    input logic [XLEN-1:0] slt_out
);
    // R6
    redirect_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !redirect);

    // R6
    redirect_implies_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> br_taken);

    // R2
    eq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_op == 3'd1 && opa == opb) |=> (br_taken && redirect));

    // R2
    ne_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_op == 3'd2 && opa == opb) |=> (!br_taken && !redirect));

    // R4
    non_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (br_op == 3'd0 || br_op == 3'd7)) |=> (!br_taken && !redirect));

    // R5
    target_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> br_target == $past(pc) + XLEN'(PC_STEP) + ($past(offset) << SHIFT));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(br_taken) && $stable(br_target)));

    // R8
    slt_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slt_out[XLEN-1:1] == '0);

    // R3
    ltz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_op == 3'd3) |=> (br_taken == $past(opa[XLEN-1])));

endmodule

bind branch_resolver brr_checker #(.XLEN(XLEN), .PC_STEP(PC_STEP), .SHIFT(SHIFT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .br_op     (br_op),
    .opa       (opa),
    .opb       (opb),
    .pc        (pc),
    .offset    (offset),
    .br_taken  (br_taken),
    .br_target (br_target),
    .redirect  (redirect),
    .slt_out   (slt_out)
);

// File: tb/sim_branch_resolver.sv
// Bench for branch_resolver: sweeps corner operands across all opcodes and
// valid levels, comparing against a model computed here.
module sim_branch_resolver;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  br_op;
    logic [31:0] opa, opb, pc, offset;
    logic        slt_unsigned;
    logic        br_taken;
    logic [31:0] br_target;
    logic        redirect;
    logic [31:0] slt_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] vals [7] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
                              32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0005,
                              32'hFFFF_FFFB};

    always #2 clk = ~clk;

    branch_resolver u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .br_op(br_op),
        .opa(opa), .opb(opb), .pc(pc), .offset(offset),
        .slt_unsigned(slt_unsigned), .br_taken(br_taken),
        .br_target(br_target), .redirect(redirect), .slt_out(slt_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit cond_of(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd1: return a == b;
            3'd2: return a != b;
            3'd3: return $signed(a) < 0;
            3'd4: return $signed(a) <= 0;
            3'd5: return $signed(a) > 0;
            3'd6: return $signed(a) >= 0;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic        exp_taken;
        logic [31:0] exp_target;
        logic        exp_redir;
        logic [31:0] exp_slt;
        int          n = 0;

        rst_n = 1'b0; in_valid = 1'b1; br_op = 3'd1;
        opa = 32'h5; opb = 32'h5; pc = 32'h100; offset = 32'h3; slt_unsigned = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears everything even with a valid taken branch present
        check("R1 taken",    {31'b0, br_taken}, 32'h0);
        check("R1 redirect", {31'b0, redirect}, 32'h0);
        check("R1 target",   br_target, 32'h0);
        check("R1 slt",      slt_out, 32'h0);
        exp_taken = 1'b0; exp_target = 32'h0;
        rst_n = 1'b1;

        for (int op = 0; op < 8; op++) begin
            for (int ia = 0; ia < 7; ia++) begin
                for (int ib = 0; ib < 7; ib++) begin
                    for (int v = 1; v >= 0; v--) begin
                        in_valid     = v[0];
                        br_op        = op[2:0];
                        opa          = vals[ia];
                        opb          = vals[ib];
                        pc           = 32'h0000_1000 + 32'(n * 4) + ((ia == 6) ? 32'hFFFF_F000 : 32'h0);
                        offset       = 32'((ia - 3) * 37 + (ib - 3) * 1001);
                        slt_unsigned = (op % 2 == 1);
                        n++;
                        exp_redir = v[0] & cond_of(br_op, opa, opb);
                        if (v[0]) begin
                            exp_taken  = cond_of(br_op, opa, opb);
                            exp_target = pc + 32'd4 + (offset << 2);
                        end
                        exp_slt = slt_unsigned ? {31'b0, opa < opb}
                                               : {31'b0, $signed(opa) < $signed(opb)};
                        @(negedge clk);
                        // R2 R3 R4 R7: outcome of last valid opcode, held otherwise
                        check(op == 1 || op == 2 ? "R2 taken" :
                              (op == 0 || op == 7) ? "R4 taken" :
                              v == 0 ? "R7 taken" : "R3 taken",
                              {31'b0, br_taken}, {31'b0, exp_taken});
                        // R6: redirect only after a valid taken branch
                        check("R6 redirect", {31'b0, redirect}, {31'b0, exp_redir});
                        // R5 R7: target load on valid, hold otherwise
                        check(v == 1 ? "R5 target" : "R7 target", br_target, exp_target);
                        // R8: set-less-than signed/unsigned
                        check("R8 slt", slt_out, exp_slt);
                    end
                end
            end
        end

        // R6: a taken branch followed by idle gives a single-cycle strobe
        in_valid = 1'b1; br_op = 3'd6; opa = 32'h0; opb = 32'h1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 pulse high", {31'b0, redirect}, 32'h1);
        @(negedge clk);
        check("R6 pulse low", {31'b0, redirect}, 32'h0);
        check("R7 taken held", {31'b0, br_taken}, 32'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule